// File: doc/BRIEF.md
# Fast Ethernet Transmit Symbol Path

This block turns a nibble-wide transmit stream into the three-level line signal used by 100 Mb/s twisted-pair Ethernet. It runs on one 125 MHz clock. On every fifth cycle it raises a strobe, and in that cycle it samples a 4-bit nibble and a frame-enable qualifier. This gives the 25 MHz, 100 Mb/s payload rate. Each sampled nibble becomes a 5-bit code group. The first two nibbles of a frame are replaced by the start delimiter. The first two slots after the enable drops carry the end delimiter. Every other slot outside a frame carries the idle group.

The code groups are serialized most significant bit first into a continuous 125 Mb/s bit stream. The stream is XORed with an 11-bit additive scrambler key sequence, and idle groups are scrambled like data. The scrambled bits then drive an MLT-3 level coder, whose output is a two-bit signed level. Framing and CRC are added upstream. The bit stream carries no check field of its own.

A far-end descrambler can lock onto the stream with no shared reset. During idle the plain bits are all ones, so eleven received bits reveal eleven key bits, and the key recurrence then predicts every later key bit.

Top module: `fe_tx_symbol`

## Requirements
- R1: `nib_stb` is high in the first cycle after reset and then in exactly one cycle of every five. `tx_en` and `txd` are sampled only in strobe cycles.
- R2: Inside a frame, every nibble after the first two is coded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: Every strobe slot that is neither part of a frame nor one of its two end-delimiter slots carries the idle group 11111.
- R4: When `tx_en` is sampled high after being idle, that nibble and the next one are replaced by 11000 and then 10001. Their data values are discarded.
- R5: The first strobe slot with `tx_en` low after a frame carries 01101, and the slot after it carries 00111. Frames are separated by at least two low slots, and every frame is at least two nibbles long.
- R6: Code groups leave back to back, most significant bit first, with no gap bits. The group sampled in a strobe cycle starts in the following cycle.
- R7: Each serial bit is XORed with key bit k[n] = k[n-11] XOR k[n-9]. This is the x^11 + x^9 + 1 recurrence, run from a nonzero seed. Eleven received bits taken during idle are enough for a receiver to descramble every later bit.
- R8: `mlt_lvl` encodes 0 as 00, +1 as 01 and −1 as 11, and never shows 10. It steps through 0, +1, 0, −1 in a cycle for each scrambled 1 bit and holds for each 0 bit. Each level shows the bit of the previous cycle.
- R9: While `rst_n` is low, `mlt_lvl` is 0 and `nib_stb` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Frame-enable qualifier, sampled in strobe cycles |
| txd | input | 4 | Transmit nibble, sampled in strobe cycles |
| nib_stb | output | 1 | High in the cycle in which a nibble is taken |
| mlt_lvl | output | 2 | Signed line level: 00 zero, 01 plus, 11 minus |

## Verification
The checker watches properties of the port signals on every cycle. It checks the one-in-five strobe spacing, the legal level codes, that the level never jumps directly between +1 and −1, that the sign alternates around zero, and the level held during reset. The code-group mapping, the delimiter replacement at both frame edges, idle fill, bit order and the scrambler recurrence are visible only in the decoded stream. The bench therefore recovers them by undoing MLT-3 and descrambling after locking on idle. It then compares each 5-bit group with the value predicted from the frames it drove, including an exhaustive sweep of all sixteen nibble values, a frame with no data and the minimum two-slot gap.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;

   localparam int NIB_W = 4;
   localparam int GRP_W = 5;

   localparam logic [GRP_W-1:0] CG_IDLE  = 5'b11111;
   localparam logic [GRP_W-1:0] CG_SSD_1 = 5'b11000;
   localparam logic [GRP_W-1:0] CG_SSD_2 = 5'b10001;
   localparam logic [GRP_W-1:0] CG_ESD_1 = 5'b01101;
   localparam logic [GRP_W-1:0] CG_ESD_2 = 5'b00111;

   typedef enum logic [1:0] {
      FR_GAP   = 2'd0,
      FR_SSD2  = 2'd1,
      FR_BODY  = 2'd2,
      FR_ESD2  = 2'd3
   } frame_st_e;

   function automatic logic [GRP_W-1:0] nib_to_grp(input logic [NIB_W-1:0] n);
      logic [GRP_W-1:0] g;
      case (n)
         4'h0: g = 5'b11110;
         4'h1: g = 5'b01001;
         4'h2: g = 5'b10100;
         4'h3: g = 5'b10101;
         4'h4: g = 5'b01010;
         4'h5: g = 5'b01011;
         4'h6: g = 5'b01110;
         4'h7: g = 5'b01111;
         4'h8: g = 5'b10010;
         4'h9: g = 5'b10011;
         4'hA: g = 5'b10110;
         4'hB: g = 5'b10111;
         4'hC: g = 5'b11010;
         4'hD: g = 5'b11011;
         4'hE: g = 5'b11100;
         default: g = 5'b11101;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/fe_cg_enc.sv
module fe_cg_enc
   import fe_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             en,
   input  logic [NIB_W-1:0] nib,
   output logic [GRP_W-1:0] grp
);

   frame_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      grp  = CG_IDLE;
      case (st_q)
         FR_GAP: begin
            if (en) begin
               grp  = CG_SSD_1;
               st_d = FR_SSD2;
            end
         end
         FR_SSD2: begin
            grp  = CG_SSD_2;
            st_d = FR_BODY;
         end
         FR_BODY: begin
            if (en) begin
               grp = nib_to_grp(nib);
            end else begin
               grp  = CG_ESD_1;
               st_d = FR_ESD2;
            end
         end
         default: begin
            grp  = CG_ESD_2;
            st_d = FR_GAP;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    st_q <= FR_GAP;
      else if (take) st_q <= st_d;
   end

endmodule

// File: rtl/fe_cg_ser.sv
module fe_cg_ser #(
   parameter int                 W      = 5,
   parameter logic [W-1:0]       RST_GRP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] grp_in,
   output logic         stb,
   output logic         bit_out
);

   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] ph_q;
   logic [W-1:0]  shf_q;

   assign stb     = (ph_q == '0);
   assign bit_out = shf_q[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         shf_q <= RST_GRP;
      end else begin
         ph_q  <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
         shf_q <= stb ? grp_in : {shf_q[W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/fe_scr.sv
module fe_scr #(
   parameter int             LEN  = 11,
   parameter int             TAP  = 9,
   parameter logic [LEN-1:0] SEED = '1,
   parameter bit             ON   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (ON) begin : g_on
         logic [LEN-1:0] sr_q;
         logic           key;
         assign key  = sr_q[LEN-1] ^ sr_q[TAP-1];
         assign dout = din ^ key;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= SEED;
            else        sr_q <= {sr_q[LEN-2:0], key};
         end
      end else begin : g_off
         assign dout = din;
      end
   endgenerate

endmodule

// File: rtl/fe_mlt3.sv
module fe_mlt3 (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       din,
   output logic [1:0] lvl
);

   logic [1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   step_q <= 2'd0;
      else if (din) step_q <= step_q + 2'd1;
   end

   always_comb begin
      case (step_q)
         2'd1:    lvl = 2'b01;
         2'd3:    lvl = 2'b11;
         default: lvl = 2'b00;
      endcase
   end

endmodule

// File: rtl/fe_tx_symbol.sv
module fe_tx_symbol
   import fe_tx_pkg::*;
#(
   parameter int                      LFSR_LEN = 11,
   parameter int                      LFSR_TAP = 9,
   parameter logic [LFSR_LEN-1:0]     SCR_SEED = '1,
   parameter bit                      SCR_ON   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_en,
   input  logic [3:0] txd,
   output logic       nib_stb,
   output logic [1:0] mlt_lvl
);

   generate
      if (LFSR_TAP < 1 || LFSR_TAP >= LFSR_LEN) begin : g_bad_tap
         $error("fe_tx_symbol: LFSR_TAP must lie in 1..LFSR_LEN-1");
      end
      if (SCR_SEED == '0) begin : g_bad_seed
         $error("fe_tx_symbol: SCR_SEED must be nonzero");
      end
      if (NIB_W != 4 || GRP_W != 5) begin : g_bad_w
         $error("fe_tx_symbol: code table assumes 4-to-5 bit groups");
      end
   endgenerate

   logic [GRP_W-1:0] grp;
   logic             plain_bit;
   logic             scr_bit;

   fe_cg_enc u_enc (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (nib_stb),
      .en    (tx_en),
      .nib   (txd),
      .grp   (grp)
   );

   fe_cg_ser #(.W(GRP_W), .RST_GRP(CG_IDLE)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .grp_in  (grp),
      .stb     (nib_stb),
      .bit_out (plain_bit)
   );

   fe_scr #(.LEN(LFSR_LEN), .TAP(LFSR_TAP), .SEED(SCR_SEED), .ON(SCR_ON)) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (plain_bit),
      .dout  (scr_bit)
   );

   fe_mlt3 u_mlt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (scr_bit),
      .lvl   (mlt_lvl)
   );

endmodule

// File: rtl/fe_tx_symbol_chk.sv
module fe_tx_symbol_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       nib_stb,
   input logic [1:0] mlt_lvl
);

   logic [2:0] since_q;
   logic [1:0] prev_q;
   logic [1:0] last_nz_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q   <= 3'd5;
         prev_q    <= 2'b00;
         last_nz_q <= 2'b11;
      end else begin
         since_q <= nib_stb ? 3'd1 : ((since_q < 3'd5) ? since_q + 3'd1 : since_q);
         prev_q  <= mlt_lvl;
         if (mlt_lvl != 2'b00) last_nz_q <= mlt_lvl;
      end
   end

   AST_STB_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      nib_stb == (since_q == 3'd5)); // R1

   AST_LVL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      mlt_lvl != 2'b10); // R8

   AST_LVL_NO_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      !((prev_q == 2'b01 && mlt_lvl == 2'b11) || (prev_q == 2'b11 && mlt_lvl == 2'b01))); // R8

   AST_LVL_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_q == 2'b00 && mlt_lvl != 2'b00) |-> (mlt_lvl != last_nz_q)); // R8

   AST_RST_LEVEL: assert property (@(posedge clk)
      !rst_n |-> (mlt_lvl == 2'b00 && nib_stb)); // R9

endmodule

bind fe_tx_symbol fe_tx_symbol_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .nib_stb (nib_stb),
   .mlt_lvl (mlt_lvl)
);

// File: tb/sim_fe_tx_symbol.sv
`timescale 1ns/1ps
module sim_fe_tx_symbol;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       tx_en = 1'b0;
   logic [3:0] txd = 4'h0;
   logic       nib_stb;
   logic [1:0] mlt_lvl;

   always #2.5 clk = ~clk;

   fe_tx_symbol u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .txd     (txd),
      .nib_stb (nib_stb),
      .mlt_lvl (mlt_lvl)
   );

   int checks = 0;
   int fails  = 0;

   localparam int MAXN = 256;
   logic        st_en  [MAXN];
   logic [3:0]  st_d   [MAXN];
   logic [4:0]  ex_g   [MAXN];
   string       ex_tag [MAXN];
   int          n_stim = 0;

   function automatic logic [4:0] code_of(input logic [3:0] v);
      logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
      return t[v];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic add_idle(input int n);
      for (int k = 0; k < n; k++) begin
         st_en[n_stim] = 1'b0; st_d[n_stim] = 4'(k + 3);
         ex_g[n_stim] = 5'b11111; ex_tag[n_stim] = "R3 idle fill";
         n_stim++;
      end
   endtask

   task automatic add_frame(input int len, input int base, input int step, input int gap);
      for (int k = 0; k < len; k++) begin
         st_en[n_stim] = 1'b1;
         st_d[n_stim]  = 4'((base + k * step) % 16);
         if (k == 0)      begin ex_g[n_stim] = 5'b11000; ex_tag[n_stim] = "R4 start first"; end
         else if (k == 1) begin ex_g[n_stim] = 5'b10001; ex_tag[n_stim] = "R4 start second"; end
         else             begin ex_g[n_stim] = code_of(st_d[n_stim]); ex_tag[n_stim] = "R2 data group"; end
         n_stim++;
      end
      for (int k = 0; k < gap; k++) begin
         st_en[n_stim] = 1'b0; st_d[n_stim] = 4'(15 - k);
         if (k == 0)      begin ex_g[n_stim] = 5'b01101; ex_tag[n_stim] = "R5 end first"; end
         else if (k == 1) begin ex_g[n_stim] = 5'b00111; ex_tag[n_stim] = "R5 end second"; end
         else             begin ex_g[n_stim] = 5'b11111; ex_tag[n_stim] = "R3 idle after frame"; end
         n_stim++;
      end
   endtask

   // receive-side model: MLT-3 undo, self-synchronising descramble, 5-bit framing
   int         ni = 0;
   int         gi = 0;
   int         nbits = 0;
   int         since = 0;
   bit         first = 1'b1;
   bit         prev_stb = 1'b0;
   logic [1:0] prev_lvl = 2'b00;
   logic [10:0] hist = '0;
   logic [4:0] acc = '0;

   task automatic step();
      logic sb, key, pb;
      if (!first) begin
         sb = (mlt_lvl != prev_lvl);               // R8 level change marks a 1
         prev_lvl = mlt_lvl;
         if (nbits < 11) key = ~sb;                 // R7 lock on idle ones
         else            key = hist[10] ^ hist[8];
         pb = sb ^ key;
         hist = {hist[9:0], key};
         nbits++;
         acc = {acc[3:0], pb};                      // R6 msb first
         if (prev_stb) begin
            if (gi > 0 && gi <= n_stim)
               chk(acc == ex_g[gi-1], $sformatf("%s (R6 R7 R8 path) group %0d", ex_tag[gi-1], gi-1),
                   int'(acc), int'(ex_g[gi-1]));
            gi++;
         end
      end
      first = 1'b0;
      if (nib_stb) begin
         if (ni > 0) chk(since == 5, "R1 strobe spacing", since, 5);
         since = 1;
         if (ni < n_stim) begin tx_en = st_en[ni]; txd = st_d[ni]; end
         else             begin tx_en = 1'b0;      txd = 4'h0;     end
         ni++;
      end else begin
         since++;
      end
      prev_stb = nib_stb;
   endtask

   initial begin
      int cyc;
      add_idle(30);
      add_frame(2, 0, 1, 3);      // frame with no data nibbles
      add_frame(18, 14, 1, 4);    // data nibbles sweep 0..F
      add_frame(10, 3, 5, 2);     // minimum gap before next frame
      add_frame(6, 9, 3, 6);
      add_frame(3, 7, 1, 8);
      add_idle(6);

      #1 rst_n = 1'b0;
      repeat (3) begin
         @(negedge clk);
         chk(mlt_lvl == 2'b00, "R9 reset level", mlt_lvl, 0);
         chk(nib_stb == 1'b1, "R9 reset strobe", nib_stb, 1);
      end
      @(negedge clk);
      rst_n = 1'b1;
      chk(nib_stb == 1'b1, "R1 first strobe", nib_stb, 1);
      step();
      cyc = 0;
      while (gi <= n_stim && cyc < 20000) begin
         @(negedge clk);
         step();
         cyc++;
      end
      if (cyc >= 20000) chk(1'b0, "watchdog", gi, n_stim + 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule